// File: doc/BRIEF.md
# Register-File LIFO Stack with Occupancy Flags

This block is a last-in first-out store of 64 words held in a small register array. A 6-bit pointer marks the top of the stack. A word register holds the value that was last written in or read out. Two single-bit flags report the full and empty states. A client raises a push request with a word on the write input, or a pop request. One clock edge later the result is on the read output and the flags.

The pointer counts modulo 64, and the flags come from that count rather than from a separate occupancy counter. A push first advances the pointer, then writes the word at the new position. Address 0 is therefore the 64th and last slot to be filled, and a push that wraps the pointer to 0 marks the stack full. A pop reads the word at the current pointer and then steps the pointer back. A pop that brings the pointer to 0 marks the stack empty.

Requests that cannot be served leave all state untouched and raise a one-cycle error pulse. These are a push while full and a pop while empty. A cycle with both requests raised is treated as a no-operation.

Top module: `lifo_regstack`

## Requirements
- R1: When reset is sampled high, the block comes up empty=1, full=0, err=0 and rd_data=0.
- R2: A push with push_req=1, pop_req=0 and full=0 stores wr_data and clears empty. On the next cycle rd_data equals that word.
- R3: A pop with pop_req=1, push_req=0 and empty=0 returns the most recently pushed word not yet popped, on rd_data one cycle later. It also clears full.
- R4: Starting from empty, the first 63 accepted pushes leave full=0. The 64th accepted push sets full=1.
- R5: The pop that removes the last stored word sets empty=1. Up to that pop, empty stays 0.
- R6: A push while full=1 is ignored. Contents, flags and rd_data are unchanged, and err is 1 for exactly the next cycle.
- R7: A pop while empty=1 is ignored. Flags and rd_data are unchanged, and err is 1 for exactly the next cycle.
- R8: A cycle with push_req=1 and pop_req=1 changes nothing: contents, flags and rd_data are unchanged, and err stays 0.
- R9: err is 0 after any cycle without an ignored request. It never remains high for a second cycle unless a new ignored request was made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Request to push wr_data |
| pop_req | input | 1 | Request to pop the top word |
| wr_data | input | DATA_W | Word to push |
| rd_data | output | DATA_W | Data register: last word pushed or popped |
| full | output | 1 | All 64 slots occupied |
| empty | output | 1 | No slots occupied |
| err | output | 1 | One-cycle pulse after an ignored push or pop |

## Verification
A corrupted pointer appears at the next pop: rd_data returns a word out of LIFO order. If the corruption crosses zero, the full or empty flag also changes at the wrong point in a fill or drain sequence. A wrong flag is visible one cycle after the request that set it, either as an error pulse where none belongs or as a missing pulse, because the flags decide which requests are accepted. Storage faults show up only when the affected slot is popped. The bench therefore fills all 64 slots and drains them completely, so every address is read back.

// File: rtl/lifo_regstack_pkg.sv
package lifo_regstack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/lifo_req_ctrl.sv
module lifo_req_ctrl
  import lifo_regstack_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op,
  output logic    err
);
  logic push_only, pop_only, bad_req;

  assign push_only = push_req && !pop_req;
  assign pop_only  = pop_req && !push_req;
  assign bad_req   = (push_only && full) || (pop_only && empty);

  always_comb begin
    op = OP_IDLE;
    if (push_only && !full)
      op = OP_PUSH;
    else if (pop_only && !empty)
      op = OP_POP;
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= bad_req;
  end
endmodule

// File: rtl/lifo_ptr_flags.sv
module lifo_ptr_flags
  import lifo_regstack_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              full,
  output logic              empty
);
  localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PTR_ZERO = '0;

  logic [ADDR_W-1:0] sp_q, sp_inc, sp_dec;

  assign sp_inc  = sp_q + PTR_ONE;
  assign sp_dec  = sp_q - PTR_ONE;
  assign wr_addr = sp_inc;
  assign rd_addr = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= PTR_ZERO;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      case (op)
        OP_PUSH: begin
          sp_q  <= sp_inc;
          full  <= (sp_inc == PTR_ZERO);
          empty <= 1'b0;
        end
        OP_POP: begin
          sp_q  <= sp_dec;
          empty <= (sp_dec == PTR_ZERO);
          full  <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lifo_store.sv
module lifo_store
  import lifo_regstack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dreg
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (op == OP_PUSH)
      mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      dreg <= '0;
    else if (op == OP_PUSH)
      dreg <= wr_data;
    else if (op == OP_POP)
      dreg <= mem[rd_addr];
  end
endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
  import lifo_regstack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              err
);
  stk_op_e           op;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  lifo_req_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .pop_req  (pop_req),
    .full     (full),
    .empty    (empty),
    .op       (op),
    .err      (err)
  );

  lifo_ptr_flags #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .full    (full),
    .empty   (empty)
  );

  lifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .wr_data (wr_data),
    .dreg    (rd_data)
  );
endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              push_req,
  input logic              pop_req,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              full,
  input logic              empty,
  input logic              err
);
  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_push_data_r2: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && !full) |=> (rd_data == $past(wr_data)) && !empty && !err);

  p_pop_clears_full_r3: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !empty) |=> !full && !err);

  p_push_full_err_r6: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && full) |=> err && full && $stable(rd_data));

  p_pop_empty_err_r7: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && empty) |=> err && empty && $stable(rd_data));

  p_both_noop_r8: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req) |=> !err && $stable(rd_data) && $stable(full) && $stable(empty));

  p_idle_no_err_r9: assert property (@(posedge clk) disable iff (rst)
    (!push_req && !pop_req) |=> !err && $stable(rd_data));
endmodule

bind lifo_regstack lifo_regstack_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .push_req (push_req),
  .pop_req  (pop_req),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .full     (full),
  .empty    (empty),
  .err      (err)
);

// File: tb/lifo_regstack_tb.sv
module lifo_regstack_tb;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVEC   = 13;

  // [20] push, [19] pop, [18:11] wr_data, [10:3] exp rd_data, [2] full, [1] empty, [0] err
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},  // R1 idle after reset
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},  // R7 pop empty
    {1'b1, 1'b0, 8'h11, 8'h11, 1'b0, 1'b0, 1'b0},  // R2
    {1'b1, 1'b0, 8'h22, 8'h22, 1'b0, 1'b0, 1'b0},  // R2
    {1'b1, 1'b1, 8'h99, 8'h22, 1'b0, 1'b0, 1'b0},  // R8 both
    {1'b1, 1'b0, 8'h33, 8'h33, 1'b0, 1'b0, 1'b0},  // R2
    {1'b0, 1'b1, 8'h00, 8'h33, 1'b0, 1'b0, 1'b0},  // R3
    {1'b0, 1'b1, 8'h00, 8'h22, 1'b0, 1'b0, 1'b0},  // R3
    {1'b1, 1'b0, 8'h44, 8'h44, 1'b0, 1'b0, 1'b0},  // R2
    {1'b0, 1'b1, 8'h00, 8'h44, 1'b0, 1'b0, 1'b0},  // R3
    {1'b0, 1'b1, 8'h00, 8'h11, 1'b0, 1'b1, 1'b0},  // R5 last pop
    {1'b0, 1'b1, 8'h00, 8'h11, 1'b0, 1'b1, 1'b1},  // R7
    {1'b0, 1'b0, 8'h00, 8'h11, 1'b0, 1'b1, 1'b0}   // R9 pulse ends
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              push_req = 1'b0;
  logic              pop_req = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              full, empty, err;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  lifo_regstack #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .pop_req  (pop_req),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .full     (full),
    .empty    (empty),
    .err      (err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic q, input logic [DATA_W-1:0] d);
    push_req = p;
    pop_req  = q;
    wr_data  = d;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, '0);
    rst = 1'b0;
  endtask

  function automatic logic [DATA_W-1:0] fill_val(input int i);
    return DATA_W'((i * 37 + 5) & 8'hff);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 full", 32'(full), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 err", 32'(err), 0);

    for (int k = 0; k < NVEC; k++) begin
      cyc(VEC[k][20], VEC[k][19], VEC[k][18:11]);
      chk($sformatf("vec%0d rd_data R2/R3/R8", k), 32'(rd_data), 32'(VEC[k][10:3]));
      chk($sformatf("vec%0d full R4", k), 32'(full), 32'(VEC[k][2]));
      chk($sformatf("vec%0d empty R5", k), 32'(empty), 32'(VEC[k][1]));
      chk($sformatf("vec%0d err R6/R7/R9", k), 32'(err), 32'(VEC[k][0]));
    end

    // R4: fill all slots
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b1, 1'b0, fill_val(i));
      if (i == DEPTH - 2) chk("R4 not full at 63", 32'(full), 0);
    end
    chk("R4 full at 64", 32'(full), 1);
    chk("R4 empty at 64", 32'(empty), 0);
    chk("R2 last data", 32'(rd_data), 32'(fill_val(DEPTH - 1)));

    // R6: push while full ignored
    cyc(1'b1, 1'b0, 8'hA5);
    chk("R6 err", 32'(err), 1);
    chk("R6 full kept", 32'(full), 1);
    chk("R6 rd_data kept", 32'(rd_data), 32'(fill_val(DEPTH - 1)));
    cyc(1'b0, 1'b0, '0);
    chk("R9 err drops", 32'(err), 0);

    // R8 while full
    cyc(1'b1, 1'b1, 8'h5A);
    chk("R8 full kept", 32'(full), 1);
    chk("R8 no err", 32'(err), 0);

    // R3/R5: drain in reverse order
    for (int i = DEPTH - 1; i >= 0; i--) begin
      cyc(1'b0, 1'b1, '0);
      chk($sformatf("R3 pop %0d", i), 32'(rd_data), 32'(fill_val(i)));
      if (i == DEPTH - 1) chk("R3 full clears", 32'(full), 0);
      if (i == 1) chk("R5 not empty before last", 32'(empty), 0);
    end
    chk("R5 empty after drain", 32'(empty), 1);
    chk("R5 no err on last pop", 32'(err), 0);

    cyc(1'b0, 1'b1, '0);
    chk("R7 err", 32'(err), 1);
    chk("R7 rd_data kept", 32'(rd_data), 32'(fill_val(0)));
    chk("R7 empty kept", 32'(empty), 1);
    cyc(1'b0, 1'b0, '0);
    chk("R9 err low", 32'(err), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule